// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block lets software drive an external serial EEPROM one bit at a time through a single eight-bit control register, while the EEPROM pins are shared with a memory port. Software sets a request bit in the register. The arbiter waits until the memory port reports that it is idle, then takes ownership of the pins. When it does, it raises a ready bit and connects the stored chip-select, clock and data-out bits to the EEPROM pins. The EEPROM's serial output is returned on the lowest register bit.

While ownership is held, every register write that keeps the request bit set clears the ready bit. Ready comes back a fixed time later, 800 ns by default, which is converted to clock cycles from a clock-period parameter. Software can therefore poll ready to pace each clock edge of the serial protocol. Clearing the request bit gives the pins back, drops ready and forces every EEPROM output low. The two top bits carry an external arbitration handshake: one bit is stored and driven out, the other is read in. The serial protocol itself is left to software.

Top module: `eeprom_port_arb`

## Requirements
- R1: After reset every stored register bit, ready, ownership and all three EEPROM output pins are 0.
- R2: The register read value is, from bit 7 down: external acknowledge input, external request, access request, ready, chip select, serial clock, data out, data in. A write stores bits 6, 5, 3, 2 and 1. Bit 6 drives the external request output, and bit 7 reads the external acknowledge input.
- R3: While the memory-busy input is 1, a pending request is not granted, and ownership and ready stay 0.
- R4: With the request bit stored as 1 and memory-busy at 0 before a clock edge, ownership and ready both become 1 at that edge. This first rise of ready carries no pacing delay.
- R5: While the port is not owned, the chip-select, clock and data-out pins are 0 and register bit 0 reads 0, whatever the stored bits and the EEPROM input hold.
- R6: While the port is owned, each EEPROM output pin equals its stored register bit, and register bit 0 equals the EEPROM data input.
- R7: While the port is owned, a write with bit 5 set clears ready at the write's clock edge. Ready returns exactly PACE_CYC clock edges later, where PACE_CYC = ceil(PACE_NS*1000 / CLK_PERIOD_PS), which is 200 at the defaults.
- R8: A write with bit 5 clear releases the port at its clock edge: ownership, ready and all three pins go to 0.
- R9: Written values of bits 7, 4 and 0 have no effect. Writing 1 to bit 4 neither sets ready nor stops a write from clearing it.
- R10: A new pacing write during a running delay restarts the delay from that write.
- R11: Once granted, ownership stays held while memory-busy is 1, until a releasing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| mem_busy | input | 1 | Memory port is serving another request |
| ee_owned | output | 1 | Arbiter holds the shared pins |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_dout | output | 1 | Serial data to the EEPROM |
| ee_din | input | 1 | Serial data from the EEPROM |
| xarb_req | output | 1 | External arbitration request |
| xarb_ack | input | 1 | External arbitration acknowledge |

## Verification
A wrong ownership state shows on the very next edge. It appears as pins driving while the memory port is still busy, or as pins that stay quiet after the request was taken. A pacing counter that is off by one, loaded with the wrong value or not restarted moves the rise of ready by one or more cycles. The reference model in the bench catches this on the exact cycle it occurs, and a separate check counts the low period of ready. A stored bit that is lost or that lands in the wrong position shows up in the read value one cycle after the write.

// File: rtl/eeprom_arb_pkg.sv
package eeprom_arb_pkg;

  // Bit positions of the control register; software decodes these.
  localparam int unsigned BIT_XACK = 7;
  localparam int unsigned BIT_XREQ = 6;
  localparam int unsigned BIT_REQ  = 5;
  localparam int unsigned BIT_RDY  = 4;
  localparam int unsigned BIT_CS   = 3;
  localparam int unsigned BIT_SK   = 2;
  localparam int unsigned BIT_DOUT = 1;
  localparam int unsigned BIT_DIN  = 0;

  localparam int unsigned N_PINS = 3;

  typedef struct packed {
    logic xack;
    logic xreq;
    logic req;
    logic rdy;
    logic cs;
    logic sk;
    logic dout;
    logic din;
  } ctl_view_t;

  function automatic int unsigned pace_cycles(input int unsigned ns, input int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/eeprom_arb_rst_sync.sv
module eeprom_arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/eeprom_arb_grant.sv
module eeprom_arb_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic req_q,
  input  logic release_wr,
  input  logic mem_busy,
  output logic owned_q,
  output logic grant_now
);
  logic owned_d;

  always_comb begin
    grant_now = !owned_q && req_q && !mem_busy && !release_wr;
    owned_d   = owned_q;
    if (release_wr)
      owned_d = 1'b0;
    else if (grant_now)
      owned_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      owned_q <= 1'b0;
    else
      owned_q <= owned_d;
  end
endmodule

// File: rtl/eeprom_arb_pacer.sv
module eeprom_arb_pacer #(
  parameter int unsigned PACE_CYC = 200,
  localparam int unsigned CNT_W   = $clog2(PACE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owned_q,
  input  logic grant_now,
  input  logic pace_wr,
  input  logic release_wr,
  output logic rdy_q
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PACE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_d;
  logic             cnt_en;

  always_comb begin
    rdy_d = rdy_q;
    cnt_d = cnt_q;
    if (release_wr) begin
      rdy_d = 1'b0;
      cnt_d = '0;
    end else if (grant_now) begin
      rdy_d = 1'b1;
      cnt_d = '0;
    end else if (pace_wr) begin
      rdy_d = 1'b0;
      cnt_d = LOAD_VAL;
    end else if (owned_q && !rdy_q) begin
      if (cnt_q == '0)
        rdy_d = 1'b1;
      else
        cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = release_wr || grant_now || pace_wr || (owned_q && !rdy_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      rdy_q <= rdy_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/eeprom_arb_pins.sv
module eeprom_arb_pins #(
  parameter int unsigned N = 3
) (
  input  logic         owned_q,
  input  logic [N-1:0] bits_q,
  output logic [N-1:0] pins
);
  for (genvar g = 0; g < N; g++) begin : g_gate
    assign pins[g] = owned_q & bits_q[g];
  end
endmodule

// File: rtl/eeprom_port_arb.sv
module eeprom_port_arb
  import eeprom_arb_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned PACE_NS       = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       mem_busy,
  output logic       ee_owned,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_dout,
  input  logic       ee_din,
  output logic       xarb_req,
  input  logic       xarb_ack
);
  localparam int unsigned PACE_CYC = pace_cycles(PACE_NS, CLK_PERIOD_PS);

  logic              rst_n_s;
  logic              xreq_q, req_q;
  logic [N_PINS-1:0] pin_bits_q, pin_bits_d, pin_out;
  logic              owned_q, grant_now, rdy_q;
  logic              release_wr, pace_wr;
  ctl_view_t         view;
  logic              unused_wbits;

  assign unused_wbits = ^{ctl_wdata[BIT_XACK], ctl_wdata[BIT_RDY], ctl_wdata[BIT_DIN]};

  eeprom_arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Shadow bits: write-enabled storage
  assign pin_bits_d = {ctl_wdata[BIT_CS], ctl_wdata[BIT_SK], ctl_wdata[BIT_DOUT]};

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      xreq_q     <= 1'b0;
      req_q      <= 1'b0;
      pin_bits_q <= '0;
    end else if (ctl_wr) begin
      xreq_q     <= ctl_wdata[BIT_XREQ];
      req_q      <= ctl_wdata[BIT_REQ];
      pin_bits_q <= pin_bits_d;
    end
  end

  assign release_wr = ctl_wr && !ctl_wdata[BIT_REQ];
  assign pace_wr    = ctl_wr &&  ctl_wdata[BIT_REQ] && owned_q;

  eeprom_arb_grant u_grant (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_q      (req_q),
    .release_wr (release_wr),
    .mem_busy   (mem_busy),
    .owned_q    (owned_q),
    .grant_now  (grant_now)
  );

  eeprom_arb_pacer #(.PACE_CYC(PACE_CYC)) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .owned_q    (owned_q),
    .grant_now  (grant_now),
    .pace_wr    (pace_wr),
    .release_wr (release_wr),
    .rdy_q      (rdy_q)
  );

  eeprom_arb_pins #(.N(N_PINS)) u_pins (
    .owned_q (owned_q),
    .bits_q  (pin_bits_q),
    .pins    (pin_out)
  );

  assign ee_cs    = pin_out[2];
  assign ee_sk    = pin_out[1];
  assign ee_dout  = pin_out[0];
  assign ee_owned = owned_q;
  assign xarb_req = xreq_q;

  always_comb begin
    view.xack = xarb_ack;
    view.xreq = xreq_q;
    view.req  = req_q;
    view.rdy  = rdy_q;
    view.cs   = pin_bits_q[2];
    view.sk   = pin_bits_q[1];
    view.dout = pin_bits_q[0];
    view.din  = ee_din & owned_q;
  end

  assign ctl_rdata = view;
endmodule

// File: rtl/eeprom_port_arb_chk.sv
module eeprom_port_arb_chk #(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned PACE_NS       = 800
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       mem_busy,
  input logic       ee_owned,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic       ee_dout,
  input logic       ee_din,
  input logic       xarb_req,
  input logic       xarb_ack
);
  localparam int unsigned PACE_CYC = eeprom_arb_pkg::pace_cycles(PACE_NS, CLK_PERIOD_PS);
  localparam int unsigned SW       = $clog2(PACE_CYC + 3);
  localparam logic [SW-1:0] SAT    = SW'(PACE_CYC + 2);

  logic [SW-1:0] since_q;
  logic          unused_chk;

  assign unused_chk = ^{xarb_req, xarb_ack, ctl_wdata[7], ctl_wdata[4], ctl_wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_q <= '0;
    else if (ctl_wr && ctl_wdata[5] && ee_owned)
      since_q <= SW'(1);
    else if (since_q != '0 && since_q != SAT)
      since_q <= since_q + 1'b1;
  end

  AST_GRANT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_owned) |-> $past(!mem_busy)); // R3

  AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_owned |-> (!ee_cs && !ee_sk && !ee_dout && !ctl_rdata[0])); // R5

  AST_DIN_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ee_owned |-> (ctl_rdata[0] == ee_din)); // R6

  AST_READY_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] |-> ee_owned); // R4

  AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_owned && ctl_wr && ctl_wdata[5]) |=> !ctl_rdata[4]); // R7

  AST_PACE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_rdata[4]) && $past(ee_owned)) |-> (since_q == SW'(PACE_CYC + 1))); // R10

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[5]) |=> (!ee_owned && !ctl_rdata[4])); // R8

  AST_HOLD_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_owned && !(ctl_wr && !ctl_wdata[5])) |=> ee_owned); // R11

  AST_SHADOW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_rdata[6:5] == $past(ctl_wdata[6:5]) && ctl_rdata[3:1] == $past(ctl_wdata[3:1]))); // R2
endmodule

bind eeprom_port_arb eeprom_port_arb_chk #(
  .CLK_PERIOD_PS(CLK_PERIOD_PS),
  .PACE_NS(PACE_NS)
) u_chk (.*);

// File: tb/eeprom_port_arb_bench.sv
`timescale 1ns/1ps
module eeprom_port_arb_bench;
  localparam int PACE_EXP = 800 / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       mem_busy = 1'b0;
  logic       ee_din = 1'b0;
  logic       xarb_ack = 1'b0;
  logic [7:0] ctl_rdata;
  logic       ee_owned, ee_cs, ee_sk, ee_dout, xarb_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  bit m_xreq, m_req, m_cs, m_sk, m_do, m_own, m_rdy;
  int m_cnt;

  always #2 clk = ~clk;

  eeprom_port_arb u_eeprom_port_arb (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .mem_busy(mem_busy), .ee_owned(ee_owned),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_dout(ee_dout), .ee_din(ee_din),
    .xarb_req(xarb_req), .xarb_ack(xarb_ack)
  );

  always @(posedge clk) begin
    bit n_own, n_rdy;
    int n_cnt;
    if (!rst_n) begin
      {m_xreq, m_req, m_cs, m_sk, m_do, m_own, m_rdy} = '0;
      m_cnt = 0;
    end else begin
      n_own = m_own; n_rdy = m_rdy; n_cnt = m_cnt;
      if (ctl_wr && !ctl_wdata[5]) begin
        n_own = 0; n_rdy = 0; n_cnt = 0;
      end else if (!m_own && m_req && !mem_busy) begin
        n_own = 1; n_rdy = 1; n_cnt = 0;
      end else if (ctl_wr && m_own) begin
        n_rdy = 0; n_cnt = PACE_EXP - 1;
      end else if (m_own && !m_rdy) begin
        if (m_cnt == 0) n_rdy = 1; else n_cnt = m_cnt - 1;
      end
      if (ctl_wr) begin
        m_xreq = ctl_wdata[6]; m_req = ctl_wdata[5];
        m_cs = ctl_wdata[3]; m_sk = ctl_wdata[2]; m_do = ctl_wdata[1];
      end
      m_own = n_own; m_rdy = n_rdy; m_cnt = n_cnt;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model rdata", ctl_rdata,
            {xarb_ack, m_xreq, m_req, m_rdy, m_cs, m_sk, m_do, ee_din & m_own});
      check("R6 model pins", {ee_owned, ee_cs, ee_sk, ee_dout, xarb_req},
            {m_own, m_own & m_cs, m_own & m_sk, m_own & m_do, m_xreq});
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!ctl_rdata[4] && n < 1000) begin
      n++;
      tick();
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    check("R1 rdata", ctl_rdata, 8'h00);
    check("R1 pins", {ee_owned, ee_cs, ee_sk, ee_dout, xarb_req}, 5'b0);
    xarb_ack = 1'b1;
    #0.1;
    check("R2 ack bit7", ctl_rdata[7], 1'b1);

    // R3 request held off while busy; R5 pins quiet
    mem_busy = 1'b1;
    ee_din = 1'b1;
    wr(8'h6F);
    repeat (5) tick();
    check("R3 owned while busy", {ee_owned, ctl_rdata[4]}, 2'b00);
    check("R5 pins before grant", {ee_cs, ee_sk, ee_dout, ctl_rdata[0]}, 4'b0000);
    check("R2 readback", ctl_rdata[6:1], 6'b110111);
    check("R9 bit0 bit4 ignored", {ctl_rdata[4], ctl_rdata[0]}, 2'b00);
    check("R2 xreq out", xarb_req, 1'b1);

    // R4 grant one edge after busy drops
    mem_busy = 1'b0;
    #0.1;
    check("R4 not yet owned", ee_owned, 1'b0);
    tick();
    check("R4 owned and ready", {ee_owned, ctl_rdata[4]}, 2'b11);
    check("R6 pins follow bits", {ee_cs, ee_sk, ee_dout}, 3'b111);
    check("R6 din returned", ctl_rdata[0], 1'b1);
    ee_din = 1'b0;
    #0.1;
    check("R6 din low", ctl_rdata[0], 1'b0);

    // R11 busy during ownership
    mem_busy = 1'b1;
    repeat (6) tick();
    check("R11 held under busy", ee_owned, 1'b1);

    // R7 and R9: pacing write with ready bit set in data
    wr(8'h34);
    check("R9 ready write ignored", ctl_rdata[4], 1'b0);
    check("R6 pins after write", {ee_cs, ee_sk, ee_dout}, 3'b010);
    count_low(n);
    check("R7 pace length", n, PACE_EXP);

    // R10 restart mid-delay
    wr(8'h28);
    repeat (50) tick();
    wr(8'h2A);
    count_low(n);
    check("R10 restart length", n, PACE_EXP);

    // R8 release
    wr(8'h0E);
    check("R8 released", {ee_owned, ctl_rdata[4], ee_cs, ee_sk, ee_dout}, 5'b0);
    repeat (3) tick();
    check("R8 stays released", ee_owned, 1'b0);

    // regrant with bit7/bit0 written, then release during a running delay
    mem_busy = 1'b0;
    xarb_ack = 1'b0;
    wr(8'hA1);
    check("R9 bit7 from input", ctl_rdata[7], 1'b0);
    tick();
    check("R4 regrant", {ee_owned, ctl_rdata[4]}, 2'b11);
    wr(8'h2C);
    repeat (10) tick();
    wr(8'h00);
    check("R8 release mid-delay", {ee_owned, ctl_rdata[4]}, 2'b00);
    repeat (PACE_EXP + 5) tick();
    check("R8 no late ready", ctl_rdata[4], 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule